// File: doc/BRIEF.md
# Shared Lock Gate Bank

A bank of byte-wide lock gates shared by several requesters. Each requester owns one port of a simple register bus, and the port index is the requester's identity. A gate holds zero while free. Otherwise it holds the owner code of the requester that holds it, which is the port index plus one. A requester claims a gate by writing its own code and then reading the gate back. If the value read equals its code, the lock is held. Any other value means the gate is busy. Only the holder can free a gate, by writing zero.

A separate control register, placed just above the gates, forcibly frees gates. It needs two writes from the same port: an arming key first and a firing key second. The second write carries a target field that selects one gate or the whole bank. Reading the control register returns the sequence state and the port that armed it, so a requester can see that another sequence is in progress. Writes from all ports that arrive in one cycle are applied in port order, lowest index first, and each one sees the effect of the ones before it. Gate contents change only through lock, release, the keyed sequence or the block reset.

Top module: `hsem_bank`

## Requirements
- R1: While `rst_n` is low, every gate is cleared to 0. At any time a gate holds only 0 (free) or an owner code in the range 1..NUM_REQ, where the code of port p is p+1.
- R2: A write to gate address a (0..NUM_GATES-1) claims the gate when the low 8 data bits equal the writing port's code and the gate is free. From the cycle after that clock edge, a read of address a on any port returns the code, zero-extended to the data width.
- R3: A claim write to a gate that another port holds leaves the gate unchanged. The writer's readback then returns the holder's code, which differs from its own.
- R4: Writing a low byte of 0 frees a gate only when the writer holds it. A zero from any other port is ignored. Every other byte value, including another port's code, is ignored and changes nothing.
- R5: Writes that arrive in the same cycle are applied in port order, port 0 first. Each later port sees the gates and control state left by the earlier ports, including a clear just performed.
- R6: The control register is at address NUM_GATES. Its write data carries a key in bits [15:8] and a target in bits [6:0]. In the idle state, key 0xE2 arms the sequence and records the port. While armed, the next control write from the same port with key 0x1D performs the clear at that clock edge.
- R7: A target of 64 or more clears every gate. A target below NUM_GATES clears only that gate. A target from NUM_GATES to 63 clears nothing.
- R8: While armed, a control write that is not key 0x1D from the arming port returns the state to idle and clears nothing. A firing key written while idle has no effect.
- R9: A read of the control register returns the state in bits [1:0] (0 idle, 1 armed, 2 clear done) and the arming port index in bits [15:8], with all other bits 0. State 2 lasts exactly the one cycle after the clear. It then becomes 0, or 1 if an arming write arrives in that cycle.
- R10: Read data is 0 while a port's enable is low. Addresses above NUM_GATES read 0, and writes to them have no effect. Reads never change any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | NUM_REQ | Per-port access enable |
| bus_we | input | NUM_REQ | Per-port write strobe (1 write, 0 read) |
| bus_addr | input | NUM_REQ x ADDR_W | Per-port word address |
| bus_wdata | input | NUM_REQ x DATA_W | Per-port write data |
| bus_rdata | output | NUM_REQ x DATA_W | Per-port read data from registered state |

## Verification
The two functions that can land in one cycle are a keyed clear and a gate claim or release from another port. Both orders are provoked directly. A lower port fires a clear on a gate while a higher port claims that gate, and the gate must end up owned. A lower port claims a free gate while a higher port fires a clear on it, and the gate must end up free. Random traffic then crowds four ports onto four gates and the control register, and a behavioural model that walks the ports in order judges every read on every clock.

// File: rtl/hsem_pkg.sv
`timescale 1ns/1ps
package hsem_pkg;

  localparam int unsigned GATE_W = 8;
  localparam int unsigned KEY_W  = 8;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_ARMED = 2'd1,
    RS_DONE  = 2'd2
  } rst_state_e;

  // Owner code of a requester port: index plus one, zero is reserved for free
  function automatic logic [GATE_W-1:0] owner_code(int unsigned idx);
    return GATE_W'(idx + 1);
  endfunction

  function automatic logic claim_ok(logic [GATE_W-1:0] wbyte,
                                    logic [GATE_W-1:0] cur,
                                    logic [GATE_W-1:0] code);
    return (wbyte == code) && (cur == '0);
  endfunction

  function automatic logic release_ok(logic [GATE_W-1:0] wbyte,
                                      logic [GATE_W-1:0] cur,
                                      logic [GATE_W-1:0] code);
    return (wbyte == '0) && (cur == code) && (code != '0);
  endfunction

  // Whether a keyed clear with the given target hits gate g
  function automatic logic clear_hits(int unsigned target,
                                      int unsigned g,
                                      int unsigned all_sel);
    return (target >= all_sel) || (target == g);
  endfunction

  function automatic logic [15:0] status_word(logic [1:0] st,
                                              logic [7:0] own);
    return {own, 6'b0, st};
  endfunction

endpackage

// File: rtl/hsem_stage.sv
`timescale 1ns/1ps
module hsem_stage
  import hsem_pkg::*;
#(
  parameter int unsigned IDX       = 0,
  parameter int unsigned NUM_GATES = 16,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REQ_W     = 2,
  parameter int unsigned SEL_W     = 7,
  parameter int unsigned ALL_SEL   = 64,
  parameter logic [KEY_W-1:0] KEY_ARM  = 8'hE2,
  parameter logic [KEY_W-1:0] KEY_FIRE = 8'h1D
) (
  input  logic                                req_en,
  input  logic                                req_we,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                   req_wdata,
  input  logic [NUM_GATES-1:0][GATE_W-1:0]    gates_in,
  input  rst_state_e                          st_in,
  input  logic [REQ_W-1:0]                    own_in,
  output logic [NUM_GATES-1:0][GATE_W-1:0]    gates_out,
  output rst_state_e                          st_out,
  output logic [REQ_W-1:0]                    own_out,
  output logic                                lock_ev,
  output logic                                rel_ev,
  output logic                                clr_ev,
  output logic                                abort_ev
);

  localparam int unsigned GIDX_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;
  localparam logic [GATE_W-1:0] MY_CODE = owner_code(IDX);

  logic              hit_gate;
  logic              hit_ctl;
  logic [GIDX_W-1:0] gidx;
  logic [GATE_W-1:0] cur;
  logic [GATE_W-1:0] wbyte;
  logic [KEY_W-1:0]  key;
  logic [SEL_W-1:0]  target;
  logic              arm_hit;

  assign hit_gate = req_en & req_we & (req_addr <  ADDR_W'(NUM_GATES));
  assign hit_ctl  = req_en & req_we & (req_addr == ADDR_W'(NUM_GATES));
  assign gidx     = req_addr[GIDX_W-1:0];
  assign cur      = gates_in[gidx];
  assign wbyte    = req_wdata[GATE_W-1:0];
  assign key      = req_wdata[DATA_W-1 -: KEY_W];
  assign target   = req_wdata[SEL_W-1:0];

  assign lock_ev  = hit_gate & claim_ok(wbyte, cur, MY_CODE);
  assign rel_ev   = hit_gate & release_ok(wbyte, cur, MY_CODE);
  assign clr_ev   = hit_ctl & (st_in == RS_ARMED) & (key == KEY_FIRE)
                  & (own_in == REQ_W'(IDX));
  assign abort_ev = hit_ctl & (st_in == RS_ARMED) & ~clr_ev;
  assign arm_hit  = hit_ctl & (st_in == RS_IDLE) & (key == KEY_ARM);

  always_comb begin
    gates_out = gates_in;
    if (lock_ev) gates_out[gidx] = MY_CODE;
    if (rel_ev)  gates_out[gidx] = '0;
    if (clr_ev) begin
      for (int unsigned g = 0; g < NUM_GATES; g++) begin
        if (clear_hits(32'(target), g, ALL_SEL)) gates_out[g] = '0;
      end
    end
  end

  always_comb begin
    st_out  = st_in;
    own_out = own_in;
    if (clr_ev)        st_out = RS_DONE;
    else if (abort_ev) st_out = RS_IDLE;
    else if (arm_hit) begin
      st_out  = RS_ARMED;
      own_out = REQ_W'(IDX);
    end
  end

endmodule

// File: rtl/hsem_rdport.sv
`timescale 1ns/1ps
module hsem_rdport
  import hsem_pkg::*;
#(
  parameter int unsigned NUM_GATES = 16,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REQ_W     = 2
) (
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_GATES-1:0][GATE_W-1:0] gates,
  input  rst_state_e                       st,
  input  logic [REQ_W-1:0]                 own,
  output logic [DATA_W-1:0]                rd_data
);

  localparam int unsigned GIDX_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_addr < ADDR_W'(NUM_GATES))
        rd_data = DATA_W'(gates[rd_addr[GIDX_W-1:0]]);
      else if (rd_addr == ADDR_W'(NUM_GATES))
        rd_data = DATA_W'(status_word(st, 8'(own)));
    end
  end

endmodule

// File: rtl/hsem_bank.sv
`timescale 1ns/1ps
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int unsigned NUM_REQ   = 4,
  parameter int unsigned NUM_GATES = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SEL_W     = 7,
  parameter int unsigned ALL_SEL   = 64,
  parameter logic [KEY_W-1:0] KEY_ARM  = 8'hE2,
  parameter logic [KEY_W-1:0] KEY_FIRE = 8'h1D,
  localparam int unsigned ADDR_W = $clog2(NUM_GATES + 1),
  localparam int unsigned REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REQ-1:0]               bus_en,
  input  logic [NUM_REQ-1:0]               bus_we,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0]   bus_addr,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]   bus_wdata,
  output logic [NUM_REQ-1:0][DATA_W-1:0]   bus_rdata
);

  // Registered state
  logic [NUM_GATES-1:0][GATE_W-1:0] gates_q;
  rst_state_e                       st_q;
  logic [REQ_W-1:0]                 own_q;

  // Per-port chain: element i is the state seen by port i
  logic [NUM_REQ:0][NUM_GATES-1:0][GATE_W-1:0] g_chain;
  rst_state_e                                  st_chain [NUM_REQ+1];
  logic [NUM_REQ:0][REQ_W-1:0]                 own_chain;

  // Named internal events for the checker
  logic [NUM_REQ-1:0] lock_ev;
  logic [NUM_REQ-1:0] rel_ev;
  logic [NUM_REQ-1:0] clr_ev;
  logic [NUM_REQ-1:0] abort_ev;

  assign g_chain[0]   = gates_q;
  assign st_chain[0]  = (st_q == RS_DONE) ? RS_IDLE : st_q;
  assign own_chain[0] = own_q;

  for (genvar p = 0; p < NUM_REQ; p++) begin : g_port
    hsem_stage #(
      .IDX(p), .NUM_GATES(NUM_GATES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .REQ_W(REQ_W), .SEL_W(SEL_W), .ALL_SEL(ALL_SEL),
      .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
    ) u_stage (
      .req_en    (bus_en[p]),
      .req_we    (bus_we[p]),
      .req_addr  (bus_addr[p]),
      .req_wdata (bus_wdata[p]),
      .gates_in  (g_chain[p]),
      .st_in     (st_chain[p]),
      .own_in    (own_chain[p]),
      .gates_out (g_chain[p+1]),
      .st_out    (st_chain[p+1]),
      .own_out   (own_chain[p+1]),
      .lock_ev   (lock_ev[p]),
      .rel_ev    (rel_ev[p]),
      .clr_ev    (clr_ev[p]),
      .abort_ev  (abort_ev[p])
    );

    hsem_rdport #(
      .NUM_GATES(NUM_GATES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_W(REQ_W)
    ) u_rd (
      .rd_en   (bus_en[p]),
      .rd_addr (bus_addr[p]),
      .gates   (gates_q),
      .st      (st_q),
      .own     (own_q),
      .rd_data (bus_rdata[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q <= '0;
      st_q    <= RS_IDLE;
      own_q   <= '0;
    end else begin
      gates_q <= g_chain[NUM_REQ];
      st_q    <= st_chain[NUM_REQ];
      own_q   <= own_chain[NUM_REQ];
    end
  end

endmodule

// File: rtl/hsem_bank_chk.sv
`timescale 1ns/1ps
module hsem_bank_chk
  import hsem_pkg::*;
#(
  parameter int unsigned NUM_REQ   = 4,
  parameter int unsigned NUM_GATES = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_GATES-1:0][GATE_W-1:0] gates,
  input rst_state_e                       st,
  input logic [NUM_REQ-1:0]               lock_ev,
  input logic [NUM_REQ-1:0]               rel_ev,
  input logic [NUM_REQ-1:0]               clr_ev,
  input logic [NUM_REQ-1:0]               abort_ev
);

  logic [NUM_GATES-1:0][GATE_W-1:0] prev_gates;
  logic lock_d, free_d;
  logic rose_any, fell_any, swap_any, code_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_gates <= '0;
      lock_d     <= 1'b0;
      free_d     <= 1'b0;
    end else begin
      prev_gates <= gates;
      lock_d     <= |lock_ev;
      free_d     <= (|rel_ev) | (|clr_ev);
    end
  end

  always_comb begin
    rose_any = 1'b0;
    fell_any = 1'b0;
    swap_any = 1'b0;
    code_bad = 1'b0;
    for (int unsigned g = 0; g < NUM_GATES; g++) begin
      if (prev_gates[g] == '0 && gates[g] != '0) rose_any = 1'b1;
      if (prev_gates[g] != '0 && gates[g] == '0) fell_any = 1'b1;
      if (prev_gates[g] != '0 && gates[g] != '0 && gates[g] != prev_gates[g])
        swap_any = 1'b1;
      if (gates[g] > GATE_W'(NUM_REQ)) code_bad = 1'b1;
    end
  end

  AST_GATE_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !code_bad) else $error("gate holds an illegal code"); // R1
  AST_CLAIM_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rose_any |-> lock_d) else $error("gate taken without a claim"); // R2
  AST_FREE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fell_any |-> free_d) else $error("gate freed without release or clear"); // R4
  AST_OWNER_SWAP_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_any |-> (free_d && lock_d)) else $error("owner replaced in place"); // R5
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_ev)) else $error("two clears in one cycle"); // R6
  AST_ABORT_CLEARS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_ev) |-> !(|clr_ev)) else $error("clear in an aborted cycle"); // R8
  AST_DONE_FOLLOWS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_ev) |=> (st == RS_DONE)) else $error("clear not reported"); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_DONE) |=> (st != RS_DONE)) else $error("done state held"); // R9

endmodule

bind hsem_bank hsem_bank_chk #(
  .NUM_REQ(NUM_REQ), .NUM_GATES(NUM_GATES)
) u_hsem_chk (
  .clk(clk), .rst_n(rst_n), .gates(gates_q), .st(st_q),
  .lock_ev(lock_ev), .rel_ev(rel_ev), .clr_ev(clr_ev), .abort_ev(abort_ev)
);

// File: tb/test_hsem_bank.sv
`timescale 1ns/1ps
module test_hsem_bank;
  localparam int NR = 4;
  localparam int NG = 16;
  localparam int AW = 5;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NR-1:0]         en;
  logic [NR-1:0]         we;
  logic [NR-1:0][AW-1:0] addr;
  logic [NR-1:0][DW-1:0] wd;
  logic [NR-1:0][DW-1:0] rd;

  hsem_bank i_hsem_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rd)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // Behavioural model
  int m_gate [NG];
  int m_st;
  int m_own;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_read(int r);
    int a;
    if (!en[r]) return 0;
    a = int'(addr[r]);
    if (a < NG) return m_gate[a];
    if (a == NG) return (m_own << 8) | m_st;
    return 0;
  endfunction

  always @(posedge clk) begin
    int a, d, key, sel;
    if (!rst_n) begin
      foreach (m_gate[g]) m_gate[g] = 0;
      m_st = 0;
      m_own = 0;
    end else begin
      if (m_st == 2) m_st = 0;
      for (int r = 0; r < NR; r++) begin
        if (en[r] && we[r]) begin
          a = int'(addr[r]);
          d = int'(wd[r]);
          if (a < NG) begin
            if ((d & 255) == r + 1 && m_gate[a] == 0) m_gate[a] = r + 1;
            else if ((d & 255) == 0 && m_gate[a] == r + 1) m_gate[a] = 0;
          end else if (a == NG) begin
            key = (d >> 8) & 255;
            sel = d & 127;
            if (m_st == 1) begin
              if (key == 'h1D && m_own == r) begin
                for (int g = 0; g < NG; g++)
                  if (sel >= 64 || sel == g) m_gate[g] = 0;
                m_st = 2;
              end else m_st = 0;
            end else if (m_st == 0 && key == 'hE2) begin
              m_st = 1;
              m_own = r;
            end
          end
        end
      end
    end
  end

  // Every-cycle comparison of all read ports against the model
  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_n && !done) begin
      for (int r = 0; r < NR; r++) begin
        if (en[r] && int'(addr[r]) == NG) check("R9 model", int'(rd[r]), m_read(r));
        else check("R2 model", int'(rd[r]), m_read(r));
      end
    end
  end

  task automatic idle();
    en = '0; we = '0; addr = '0; wd = '0;
  endtask

  task automatic wr(int r, int a, int d);
    en[r] = 1'b1; we[r] = 1'b1; addr[r] = AW'(a); wd[r] = DW'(d);
  endtask

  task automatic commit();
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(int r, int a, int exp, string req);
    en[r] = 1'b1; we[r] = 1'b0; addr[r] = AW'(a);
    #0.2;
    check(req, int'(rd[r]), exp);
    en[r] = 1'b0;
  endtask

  task automatic do_reset();
    cmp_on = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int pick, v, k, s, keyv, selv;
    idle();
    do_reset();

    // R1 reset state
    rd_chk(0, 5, 0, "R1");
    rd_chk(1, NG, 0, "R9");
    rd_chk(2, 20, 0, "R10");

    // R2 claim
    wr(1, 3, 2); commit();
    rd_chk(1, 3, 2, "R2");
    rd_chk(2, 3, 2, "R1");
    // R3 busy
    wr(2, 3, 3); commit();
    rd_chk(2, 3, 2, "R3");
    // R4 release rules
    wr(2, 3, 0); commit();
    rd_chk(0, 3, 2, "R4");
    wr(1, 7, 4); commit();
    rd_chk(0, 7, 0, "R4");
    wr(1, 3, 0); commit();
    rd_chk(0, 3, 0, "R4");
    // R2 upper data bits ignored on gates
    wr(2, 8, 'hAB03); commit();
    rd_chk(0, 8, 3, "R2");
    // R10 out of range write
    wr(3, 25, 4); commit();
    rd_chk(3, 25, 0, "R10");

    // R5 same-cycle ordering
    wr(0, 9, 1); wr(3, 9, 4); commit();
    rd_chk(0, 9, 1, "R5");
    wr(0, 9, 0); wr(2, 9, 3); commit();
    rd_chk(0, 9, 3, "R5");
    wr(1, 9, 2); wr(2, 9, 0); commit();
    rd_chk(0, 9, 0, "R5");

    // R6/R7 keyed clear of one gate
    wr(3, 4, 4); wr(0, 6, 1); commit();
    wr(1, NG, 'hE200); commit();
    rd_chk(2, NG, 'h0101, "R9");
    wr(1, NG, 'h1D04); commit();
    rd_chk(0, NG, 'h0102, "R9");
    rd_chk(1, 4, 0, "R6");
    rd_chk(2, 6, 1, "R7");
    commit();
    rd_chk(0, NG, 'h0100, "R9");
    // R7 target in gap clears nothing
    wr(1, NG, 'hE200); commit();
    wr(1, NG, 'h1D14); commit();
    rd_chk(0, 6, 1, "R7");
    rd_chk(0, 8, 3, "R7");
    commit();
    // R7 clear all with target 100
    wr(3, 4, 4); wr(2, 11, 3); commit();
    wr(2, NG, 'hE200); commit();
    wr(2, NG, 'h1D64); commit();
    rd_chk(0, NG, 'h0202, "R9");
    rd_chk(0, 4, 0, "R7");
    rd_chk(1, 6, 0, "R7");
    rd_chk(2, 11, 0, "R7");
    commit();
    // R7 clear all with target exactly 64
    wr(0, 0, 1); commit();
    wr(3, NG, 'hE200); commit();
    rd_chk(0, NG, 'h0301, "R9");
    wr(3, NG, 'h1D40); commit();
    rd_chk(0, 0, 0, "R7");
    commit();

    // R8 abort by another port
    wr(0, 5, 1); commit();
    wr(0, NG, 'hE200); commit();
    wr(1, NG, 'h1D40); commit();
    rd_chk(0, NG, 'h0000, "R8");
    rd_chk(1, 5, 1, "R8");
    // R8 abort by wrong key, then fire while idle
    wr(0, NG, 'hE200); commit();
    wr(0, NG, 'h5540); commit();
    rd_chk(0, NG, 'h0000, "R8");
    wr(0, NG, 'h1D40); commit();
    rd_chk(0, 5, 1, "R8");
    rd_chk(0, NG, 'h0000, "R8");

    // R5 clear then claim in the same cycle
    wr(3, 2, 4); commit();
    wr(0, NG, 'hE200); commit();
    wr(0, NG, 'h1D02); wr(1, 2, 2); commit();
    rd_chk(0, 2, 2, "R5");
    commit();
    // R5 claim then clear in the same cycle
    wr(3, NG, 'hE200); commit();
    wr(0, 12, 1); wr(3, NG, 'h1D0C); commit();
    rd_chk(0, 12, 0, "R5");
    // R9 re-arm in the done cycle
    wr(2, NG, 'hE200); commit();
    rd_chk(0, NG, 'h0201, "R9");
    wr(2, NG, 'h0000); commit();

    // R1 block reset clears held gates
    do_reset();
    rd_chk(0, 5, 0, "R1");
    rd_chk(0, 2, 0, "R1");

    // Random contention phase, judged by the model every cycle
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      idle();
      for (int r = 0; r < NR; r++) begin
        pick = $urandom_range(0, 9);
        if (pick < 3) begin
          en[r] = 1'b1; addr[r] = AW'($urandom_range(0, NG + 1));
        end else if (pick < 7) begin
          v = $urandom_range(0, 5);
          if (v == 5) v = $urandom_range(0, 255);
          wr(r, $urandom_range(0, 3), v | ($urandom_range(0, 255) << 8));
        end else if (pick < 9) begin
          k = $urandom_range(0, 2);
          keyv = (k == 0) ? 'hE2 : (k == 1) ? 'h1D : $urandom_range(0, 255);
          s = $urandom_range(0, 3);
          selv = (s == 0) ? $urandom_range(0, 3) : (s == 1) ? 64 : (s == 2) ? 20 : 127;
          wr(r, NG, (keyv << 8) | selv);
        end else begin
          wr(r, $urandom_range(NG + 1, 31), $urandom_range(1, 4));
        end
      end
    end
    @(negedge clk);
    idle();
    @(negedge clk);
    finish_run();
  end

endmodule